// File: doc/BRIEF.md
# Tagged-FIFO Parallel Port Forward Transmitter

This block carries bytes from a host processor to a peripheral over an 8-bit parallel bus. Software writes bytes through a small register port. A write to the data address queues the byte as data. A write to the command address queues it as a command. For a command byte, bit 7 tells the peripheral whether bits 6:0 are a channel address or a run-length count. Both kinds of byte share a single tagged 16-entry FIFO, so they leave in the exact order they were written.

On the bus side, a sequencer removes each entry from the FIFO and places it on the bus with no software involvement. It drives the type line low for a command and high for data. It then pulls the strobe low and waits for the peripheral to raise busy. After that it releases the strobe and pops the entry. The block also reports occupancy, full, empty and a sticky overflow flag. It can raise a service request when the queue drains down to a programmable level.

Top module: `ppt_fwd_xmit`

## Requirements
- R1: After reset, nstrobe and host_ack are high, fifo_empty is 1, fifo_full, overflow and service_req are 0, and fifo_level is 0.
- R2: A byte written at address 0 (data) is sent on pdata unchanged, with host_ack high, and bytes leave in the order they were written.
- R3: A byte written at address 1 (command) is sent on pdata unchanged, with host_ack low. Bit 7 is the address/run-length selector and bits 6:0 are its value.
- R4: Each transfer waits for busy to be low, presents the byte, and then pulls nstrobe low. nstrobe stays low with pdata stable until busy is seen high. nstrobe then returns high and the entry is removed.
- R5: While busy is held high, nstrobe stays high even when the FIFO holds bytes.
- R6: fifo_full is 1 when 16 entries are queued. A data or command write while full is dropped and sets overflow, which stays set until a write to address 2 with bit 5 set.
- R7: fifo_empty is 1 only when no entry is queued and no transfer is in progress, and fifo_level reports the number of queued entries, including one in flight.
- R8: Address 3 sets the threshold. Address 2 bit 0 enables the service request, and bit 4 clears it. When enabled, service_req becomes 1 when an entry is removed and the remaining occupancy is at or below the threshold. While disabled, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 command, 2 control, 3 threshold |
| wr_data | input | 8 | Write value |
| busy | input | 1 | Peripheral busy handshake (asynchronous) |
| pdata | output | 8 | Parallel data bus |
| nstrobe | output | 1 | Active-low strobe |
| host_ack | output | 1 | Byte type: low for command, high for data |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | Nothing queued or in flight |
| fifo_level | output | LW (5) | Queued entry count |
| overflow | output | 1 | Sticky dropped-write flag |
| service_req | output | 1 | Sticky service request |

## Verification
A corrupted FIFO pointer or tag shows up at the very next strobe as a wrong byte or a wrong host_ack level, so every received byte is compared against the order in which it was written. A sequencer stuck in the wrong state appears within a few cycles in one of two ways. Either nstrobe fails to fall while busy is low, or it fails to rise after busy is raised. A wrong occupancy count surfaces as a wrong fifo_level immediately after each write. It also surfaces as a premature full flag or as a service request that arrives one pop too early or too late.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    typedef enum logic [1:0] {
        REG_DATA   = 2'd0,
        REG_CMD    = 2'd1,
        REG_CTRL   = 2'd2,
        REG_THRESH = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] value;
    } fifo_word_t;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SETUP  = 2'd1,
        TX_STROBE = 2'd2
    } tx_state_e;

    localparam int CTRL_IRQ_EN  = 0;
    localparam int CTRL_CLR_SVC = 4;
    localparam int CTRL_CLR_OVF = 5;

    function automatic logic is_queue_addr(input logic [1:0] a);
        return (a == REG_DATA) || (a == REG_CMD);
    endfunction

    function automatic fifo_word_t make_word(input logic [1:0] a, input logic [7:0] d);
        fifo_word_t w;
        w.is_cmd = (a == REG_CMD);
        w.value  = d;
        return w;
    endfunction

endpackage

// File: rtl/ppt_tag_fifo.sv
module ppt_tag_fifo
    import ppt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  fifo_word_t    push_word,
    input  logic          pop,
    output fifo_word_t    head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_word_t    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    logic do_push, do_pop;
    assign do_push = push && (cnt != LW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign level = cnt;
    assign full  = (cnt == LW'(DEPTH));
    assign empty = (cnt == '0);
endmodule

// File: rtl/ppt_strobe_ctl.sv
module ppt_strobe_ctl
    import ppt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy_s,
    input  logic       avail,
    input  fifo_word_t head,
    output logic       pop,
    output logic [7:0] pdata,
    output logic       host_ack,
    output logic       nstrobe
);
    tx_state_e  state;
    fifo_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            word_q <= '0;
        end else begin
            case (state)
                TX_IDLE: if (avail && !busy_s) begin
                    word_q <= head;
                    state  <= TX_SETUP;
                end
                TX_SETUP:  state <= TX_STROBE;
                TX_STROBE: if (busy_s) state <= TX_IDLE;
                default:   state <= TX_IDLE;
            endcase
        end
    end

    assign pop      = (state == TX_STROBE) && busy_s;
    assign nstrobe  = (state != TX_STROBE);
    assign pdata    = word_q.value;
    assign host_ack = !word_q.is_cmd;
endmodule

// File: rtl/ppt_svc_flags.sv
module ppt_svc_flags
    import ppt_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          full,
    input  logic          pushed,
    input  logic          popped,
    input  logic [LW-1:0] level,
    output logic [LW-1:0] thresh_q,
    output logic          irq_en_q,
    output logic          overflow,
    output logic          service_req
);
    logic          ctrl_wr, drop;
    logic [LW-1:0] next_level;

    assign ctrl_wr    = wr_en && (wr_addr == REG_CTRL);
    assign drop       = wr_en && is_queue_addr(wr_addr) && full;
    assign next_level = level + LW'(pushed) - LW'(popped);

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh_q    <= '0;
            irq_en_q    <= 1'b0;
            overflow    <= 1'b0;
            service_req <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == REG_THRESH)) thresh_q <= wr_data[LW-1:0];
            if (ctrl_wr) irq_en_q <= wr_data[CTRL_IRQ_EN];

            if (drop)                                overflow <= 1'b1;
            else if (ctrl_wr && wr_data[CTRL_CLR_OVF]) overflow <= 1'b0;

            if (popped && irq_en_q && (next_level <= thresh_q)) service_req <= 1'b1;
            else if (ctrl_wr && wr_data[CTRL_CLR_SVC])           service_req <= 1'b0;
        end
    end
endmodule

// File: rtl/ppt_fwd_xmit.sv
module ppt_fwd_xmit
    import ppt_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    output logic [7:0]    pdata,
    output logic          nstrobe,
    output logic          host_ack,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic [LW-1:0] fifo_level,
    output logic          overflow,
    output logic          service_req
);
    logic          busy_s, push, pop, q_empty, irq_en_q;
    logic [LW-1:0] thresh_q;
    fifo_word_t    head;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign busy_s = busy;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], busy} ;
            end
            assign busy_s = sr[SYNC_STAGES-1];
        end
    endgenerate

    assign push = wr_en && is_queue_addr(wr_addr) && !fifo_full;

    ppt_tag_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (make_word(wr_addr, wr_data)),
        .pop       (pop),
        .head      (head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (q_empty)
    );

    ppt_strobe_ctl u_strobe (
        .clk      (clk),
        .rst      (rst),
        .busy_s   (busy_s),
        .avail    (!q_empty),
        .head     (head),
        .pop      (pop),
        .pdata    (pdata),
        .host_ack (host_ack),
        .nstrobe  (nstrobe)
    );

    ppt_svc_flags #(.LW(LW)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .full        (fifo_full),
        .pushed      (push),
        .popped      (pop),
        .level       (fifo_level),
        .thresh_q    (thresh_q),
        .irq_en_q    (irq_en_q),
        .overflow    (overflow),
        .service_req (service_req)
    );

    // The in-flight entry is popped only at handshake end, so an empty
    // queue also means no transfer is under way.
    assign fifo_empty = q_empty && nstrobe;
endmodule

// File: rtl/ppt_fwd_xmit_chk.sv
module ppt_fwd_xmit_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [7:0]    pdata,
    input logic          nstrobe,
    input logic          busy_s,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [LW-1:0] fifo_level,
    input logic          overflow,
    input logic          service_req,
    input logic [LW-1:0] thresh_q
);
    // R4
    strobe_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!nstrobe && $past(!nstrobe)) |-> $stable(pdata));

    // R4
    strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nstrobe) |-> $past(busy_s));

    // R6
    full_level_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (fifo_level == LW'(DEPTH)));

    // R6
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(wr_en && fifo_full && (wr_addr[1] == 1'b0)));

    // R7
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> (fifo_level == '0) && nstrobe);

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    // R8
    service_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(service_req) |-> (fifo_level <= thresh_q));
endmodule

bind ppt_fwd_xmit ppt_fwd_xmit_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/ppt_fwd_xmit_tb.sv
module ppt_fwd_xmit_tb;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic [7:0]    pdata;
    logic          nstrobe, host_ack, fifo_full, fifo_empty, overflow, service_req;
    logic [LW-1:0] fifo_level;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ppt_fwd_xmit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .pdata(pdata), .nstrobe(nstrobe), .host_ack(host_ack),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
        .overflow(overflow), .service_req(service_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Acts as the peripheral: waits for the strobe, checks the byte, answers with busy.
    task automatic recv(input string req, input logic [7:0] exp_b, input logic exp_ack);
        int k = 0;
        @(negedge clk);
        while (nstrobe && k < 200) begin @(negedge clk); k++; end
        check({req, " strobe seen"}, nstrobe, 0);
        check({req, " pdata"}, pdata, exp_b);
        check({req, " host_ack"}, host_ack, exp_ack);
        check("R7 not empty in flight", fifo_empty, 0);
        idle(3);
        check("R4 held until busy", nstrobe, 0);
        busy = 1'b1;
        k = 0;
        while (!nstrobe && k < 200) begin @(negedge clk); k++; end
        check("R4 release after busy", nstrobe, 1);
        busy = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 nstrobe", nstrobe, 1);
        check("R1 host_ack", host_ack, 1);
        check("R1 empty", fifo_empty, 1);
        check("R1 full", fifo_full, 0);
        check("R1 overflow", overflow, 0);
        check("R1 service_req", service_req, 0);
        check("R1 level", fifo_level, 0);
    endtask

    task automatic t_order;
        wr(0, 8'hA5); wr(1, 8'h83); wr(0, 8'h3C); wr(1, 8'h12);
        check("R7 level after writes", fifo_level, 4);
        recv("R2 data first", 8'hA5, 1'b1);
        recv("R3 command rle", 8'h83, 1'b0);
        recv("R2 data third", 8'h3C, 1'b1);
        recv("R3 command addr", 8'h12, 1'b0);
        idle(5);
        check("R7 empty after drain", fifo_empty, 1);
        check("R7 level after drain", fifo_level, 0);
    endtask

    task automatic t_busy_hold;
        busy = 1'b1;
        idle(4);
        wr(0, 8'h5A);
        idle(20);
        check("R5 no strobe while busy", nstrobe, 1);
        check("R5 entry kept", fifo_level, 1);
        busy = 1'b0;
        recv("R5 sent after busy low", 8'h5A, 1'b1);
        idle(5);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < DEPTH; i++) wr(i[0] ? 2'd1 : 2'd0, 8'(i + 8'h40));
        check("R6 full", fifo_full, 1);
        check("R6 level", fifo_level, DEPTH);
        check("R6 no overflow yet", overflow, 0);
        wr(0, 8'hEE);
        check("R6 overflow set", overflow, 1);
        check("R6 level unchanged", fifo_level, DEPTH);
        for (int i = 0; i < DEPTH; i++) recv("R6 drain", 8'(i + 8'h40), !i[0]);
        idle(20);
        check("R6 dropped byte not sent", nstrobe, 1);
        check("R6 empty", fifo_empty, 1);
        check("R6 overflow sticky", overflow, 1);
        wr(2, 8'h20);
        check("R6 overflow cleared", overflow, 0);
    endtask

    task automatic t_service;
        wr(3, 8'd1);
        wr(2, 8'h01);
        for (int i = 0; i < 4; i++) wr(0, 8'(8'h70 + i));
        recv("R8 pop1", 8'h70, 1'b1);
        recv("R8 pop2", 8'h71, 1'b1);
        @(negedge clk);
        check("R8 above threshold", service_req, 0);
        recv("R8 pop3", 8'h72, 1'b1);
        check("R8 set at threshold", service_req, 1);
        wr(2, 8'h11);
        check("R8 cleared", service_req, 0);
        recv("R8 pop4", 8'h73, 1'b1);
        check("R8 set below threshold", service_req, 1);
        wr(2, 8'h10);
        check("R8 clear and disable", service_req, 0);
        wr(0, 8'h01); wr(0, 8'h02);
        recv("R8 dis pop1", 8'h01, 1'b1);
        recv("R8 dis pop2", 8'h02, 1'b1);
        idle(3);
        check("R8 disabled stays low", service_req, 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_order;
        t_busy_hold;
        t_overflow;
        t_service;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule